// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit keeps the segment and offset state of a 16-bit segmented machine and turns it into 20-bit physical addresses. It holds three 16-bit segment bases, for code, stack and data, plus the instruction pointer and the stack pointer. For each access it picks the segment that matches the kind of access and the offset that goes with it. It then shifts the segment left by four bits and adds the offset.

A sequencer next to the unit loads registers through a single write port. It raises an access request with a kind code, and for data accesses it also supplies a displacement. It advances the instruction pointer with a strobe and a step size. Push and pop are access kinds, and they move the stack pointer as a side effect. The address comes out of a register one clock after the request, together with a valid flag.

Top module: `seg_agu`

## Requirements
- R1: After reset the three segment registers, the instruction pointer and the stack pointer are all zero, and `addr_valid` is low.
- R2: The physical address is (segment × 16 + offset) taken modulo 2^20, with no carry kept past bit 19. For example, code segment 0x2104 with instruction pointer 0x0042 gives 0x21082, and segment 0xFFFF with offset 0x0010 gives 0x00000.
- R3: The `acc_kind` codes are 0 = fetch, 1 = push, 2 = pop and 3 = data. A fetch uses the code segment and the instruction pointer. A data access uses the data segment and `acc_disp`. A fetch in the same cycle as an advance uses the pointer value from before the advance.
- R4: When `ip_adv` is high, the instruction pointer grows by `ip_step` modulo 2^16. Passing 0xFFFF wraps it to 0x0000, and the code segment is left unchanged.
- R5: A push first lowers the stack pointer by 2 modulo 2^16. It then issues stack segment + the new pointer.
- R6: A pop issues stack segment + the current pointer. It then raises the stack pointer by 2 modulo 2^16.
- R7: `addr_valid` is high in exactly the one cycle that follows each cycle with `acc_req` high, and low after every cycle without a request.
- R8: A register write takes effect only for accesses in later cycles. An access in the same cycle as a segment write still uses the old segment value.
- R9: The `reg_wr_sel` codes are 0 = code segment, 1 = stack segment, 2 = data segment, 3 = instruction pointer and 4 = stack pointer. Codes 5 to 7 change nothing. A write to the instruction pointer or the stack pointer wins over an advance, push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for the write |
| reg_wr_data | input | 16 | Value to write |
| acc_req | input | 1 | Access request |
| acc_kind | input | 2 | Kind of access |
| acc_disp | input | 16 | Displacement for data accesses |
| ip_adv | input | 1 | Advance the instruction pointer |
| ip_step | input | 4 | Amount to advance by |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | Address valid, one cycle per request |

## Verification
The hardest situations to reach are collisions inside one cycle. These include a segment write together with an access that must still see the old segment, a pointer write together with a push, pop or advance, and a fetch together with an advance. The stimulus builds each of these on purpose and checks the access in the next cycle to prove that the old value was used. A later access then proves that the new value took hold.

Wrap cases also need the pointers steered to the ends of their range. The bench loads values next to 0xFFFF and a segment of 0xFFFF, and it pops from a freshly pushed pointer of 0xFFFE. A long random mix then stacks these collisions against a model kept in the bench.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_PUSH  = 2'd1,
        ACC_POP   = 2'd2,
        ACC_DATA  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        RSEL_CODE  = 3'd0,
        RSEL_STACK = 3'd1,
        RSEL_DATA  = 3'd2,
        RSEL_IP    = 3'd3,
        RSEL_SP    = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/seg_agu_form.sv
module seg_agu_form #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int PA_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  pa
);
    // base is the segment on a 2^SHIFT boundary; sum truncates to PA_W bits
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] off_ext;

    always_comb begin
        base    = {seg, {SHIFT{1'b0}}};
        off_ext = PA_W'(off);
        pa      = base + off_ext;
    end
endmodule

// File: rtl/seg_agu_regs.sv
module seg_agu_regs
    import seg_agu_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int OFF_W    = 16,
    parameter int STEP_W   = 4,
    parameter int STK_STEP = 2,
    localparam int DW      = (SEG_W > OFF_W) ? SEG_W : OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              ip_adv,
    input  logic [STEP_W-1:0] ip_step,
    input  logic              push,
    input  logic              pop,
    output logic [SEG_W-1:0]  cs,
    output logic [SEG_W-1:0]  ss,
    output logic [SEG_W-1:0]  ds,
    output logic [OFF_W-1:0]  ip,
    output logic [OFF_W-1:0]  sp
);
    typedef struct packed {
        logic [SEG_W-1:0] cs;
        logic [SEG_W-1:0] ss;
        logic [SEG_W-1:0] ds;
        logic [OFF_W-1:0] ip;
        logic [OFF_W-1:0] sp;
    } arch_t;

    arch_t st_d, st_q;
    logic  ip_wr, sp_wr;

    always_comb begin
        st_d  = st_q;
        ip_wr = wr_en && (wr_sel == RSEL_IP);
        sp_wr = wr_en && (wr_sel == RSEL_SP);
        if (wr_en) begin
            case (wr_sel)
                RSEL_CODE:  st_d.cs = wr_data[SEG_W-1:0];
                RSEL_STACK: st_d.ss = wr_data[SEG_W-1:0];
                RSEL_DATA:  st_d.ds = wr_data[SEG_W-1:0];
                default:    ;
            endcase
        end
        if (ip_wr)       st_d.ip = wr_data[OFF_W-1:0];
        else if (ip_adv) st_d.ip = st_q.ip + OFF_W'(ip_step);
        if (sp_wr)       st_d.sp = wr_data[OFF_W-1:0];
        else if (push)   st_d.sp = st_q.sp - OFF_W'(STK_STEP);
        else if (pop)    st_d.sp = st_q.sp + OFF_W'(STK_STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs = st_q.cs;
    assign ss = st_q.ss;
    assign ds = st_q.ds;
    assign ip = st_q.ip;
    assign sp = st_q.sp;

    AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        push && !(wr_en && wr_sel == RSEL_SP) |=> sp == OFF_W'($past(sp) - OFF_W'(STK_STEP))); // R5
    AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !(wr_en && wr_sel == RSEL_SP) |=> sp == OFF_W'($past(sp) + OFF_W'(STK_STEP))); // R6
    AST_IP_ADV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ip_adv && !wr_en |=> ip == OFF_W'($past(ip) + OFF_W'($past(ip_step))) && $stable(cs)); // R4
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cs) && $stable(ss) && $stable(ds)); // R9
    AST_PTR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == RSEL_SP |=> sp == $past(wr_data[OFF_W-1:0])); // R9
endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int SEG_W    = 16,
    parameter int OFF_W    = 16,
    parameter int SHIFT    = 4,
    parameter int STEP_W   = 4,
    parameter int STK_STEP = 2,
    localparam int PA_W    = SEG_W + SHIFT,
    localparam int DW      = (SEG_W > OFF_W) ? SEG_W : OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [DW-1:0]     reg_wr_data,
    input  logic              acc_req,
    input  logic [1:0]        acc_kind,
    input  logic [OFF_W-1:0]  acc_disp,
    input  logic              ip_adv,
    input  logic [STEP_W-1:0] ip_step,
    output logic [PA_W-1:0]   phys_addr,
    output logic              addr_valid
);
    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] addr;
    } out_t;

    logic [SEG_W-1:0] cs, ss, ds, sel_seg;
    logic [OFF_W-1:0] ip, sp, sel_off;
    logic [PA_W-1:0]  pa;
    logic             do_push, do_pop;
    out_t             out_d, out_q;

    assign do_push = acc_req && (acc_kind == ACC_PUSH);
    assign do_pop  = acc_req && (acc_kind == ACC_POP);

    seg_agu_regs #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .STEP_W(STEP_W), .STK_STEP(STK_STEP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
        .ip_adv(ip_adv), .ip_step(ip_step),
        .push(do_push), .pop(do_pop),
        .cs(cs), .ss(ss), .ds(ds), .ip(ip), .sp(sp)
    );

    seg_agu_form #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)
    ) u_form (
        .seg(sel_seg), .off(sel_off), .pa(pa)
    );

    always_comb begin
        case (acc_kind)
            ACC_FETCH: begin sel_seg = cs; sel_off = ip; end
            ACC_PUSH:  begin sel_seg = ss; sel_off = sp - OFF_W'(STK_STEP); end
            ACC_POP:   begin sel_seg = ss; sel_off = sp; end
            default:   begin sel_seg = ds; sel_off = acc_disp; end
        endcase
        out_d.vld  = acc_req;
        out_d.addr = acc_req ? pa : out_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign phys_addr  = out_q.addr;
    assign addr_valid = out_q.vld;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> addr_valid); // R7
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !addr_valid); // R7
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_kind == ACC_FETCH |=>
        phys_addr == PA_W'({$past(cs), {SHIFT{1'b0}}} + PA_W'($past(ip)))); // R3
    AST_DATA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_kind == ACC_DATA |=>
        phys_addr == PA_W'({$past(ds), {SHIFT{1'b0}}} + PA_W'($past(acc_disp)))); // R8
endmodule

// File: tb/seg_agu_bench.sv
module seg_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [15:0] reg_wr_data = '0;
    logic        acc_req = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [15:0] acc_disp = '0;
    logic        ip_adv = 1'b0;
    logic [3:0]  ip_step = '0;
    logic [19:0] phys_addr;
    logic        addr_valid;

    int checks = 0;
    int fails  = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_cs = 0, m_ss = 0, m_ds = 0, m_ip = 0, m_sp = 0;

    always #10 clk = ~clk;

    seg_agu u_seg_agu (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .acc_req(acc_req), .acc_kind(acc_kind), .acc_disp(acc_disp),
        .ip_adv(ip_adv), .ip_step(ip_step),
        .phys_addr(phys_addr), .addr_valid(addr_valid)
    );

    function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
        return 20'(seg * 20'd16 + off);
    endfunction

    task automatic cyc(input logic req, input logic [1:0] kind, input logic [15:0] disp,
                       input logic wen, input logic [2:0] wsel, input logic [15:0] wdata,
                       input logic adv, input logic [3:0] step, input string tag);
        logic [15:0] nsp;
        @(negedge clk);
        acc_req = req; acc_kind = kind; acc_disp = disp;
        reg_wr_en = wen; reg_wr_sel = wsel; reg_wr_data = wdata;
        ip_adv = adv; ip_step = step;
        nsp = m_sp;
        if (req) begin
            case (kind)
                2'd0: exp_q.push_back(phys(m_cs, m_ip));
                2'd1: exp_q.push_back(phys(m_ss, 16'(m_sp - 16'd2)));
                2'd2: exp_q.push_back(phys(m_ss, m_sp));
                default: exp_q.push_back(phys(m_ds, disp));
            endcase
            tag_q.push_back(tag);
            if (kind == 2'd1) nsp = 16'(m_sp - 16'd2);
            if (kind == 2'd2) nsp = 16'(m_sp + 16'd2);
        end
        if (adv) m_ip = 16'(m_ip + 16'(step));
        m_sp = nsp;
        if (wen) begin
            case (wsel)
                3'd0: m_cs = wdata;
                3'd1: m_ss = wdata;
                3'd2: m_ds = wdata;
                3'd3: m_ip = wdata;
                3'd4: m_sp = wdata;
                default: ;
            endcase
        end
    endtask

    task automatic acc(input logic [1:0] kind, input logic [15:0] disp, input string tag);
        cyc(1'b1, kind, disp, 1'b0, 3'd0, 16'd0, 1'b0, 4'd0, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        cyc(1'b0, 2'd0, 16'd0, 1'b1, sel, data, 1'b0, 4'd0, "R9");
    endtask

    task automatic idle();
        cyc(1'b0, 2'd0, 16'd0, 1'b0, 3'd0, 16'd0, 1'b0, 4'd0, "R7");
    endtask

    // monitor: compare the scoreboard head once per cycle, after outputs settle
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            checks++;
            if (addr_valid !== (exp_q.size() > 0)) begin
                fails++;
                $display("FAIL R7 valid actual=%0b expected=%0b", addr_valid, exp_q.size() > 0);
                if (exp_q.size() > 0) begin
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end else if (addr_valid) begin
                logic [19:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (phys_addr !== e) begin
                    fails++;
                    $display("FAIL %s addr actual=%05h expected=%05h", t, phys_addr, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (addr_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid in reset actual=%0b expected=0", addr_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        acc(2'd0, 16'd0, "R1 fetch after reset");
        acc(2'd1, 16'd0, "R1 R5 push from zero sp");
        acc(2'd2, 16'd0, "R6 pop at 0xFFFE wraps");
        idle();
        wr(3'd0, 16'h2104);
        wr(3'd3, 16'h0042);
        acc(2'd0, 16'd0, "R2 R3 fetch 0x21082");
        wr(3'd2, 16'hFFFF);
        acc(2'd3, 16'h0010, "R2 wrap past 0xFFFFF");
        acc(2'd3, 16'h000F, "R2 top address");
        cyc(1'b1, 2'd3, 16'h0005, 1'b1, 3'd2, 16'h1000, 1'b0, 4'd0, "R8 old data segment");
        acc(2'd3, 16'h0005, "R8 new data segment");
        cyc(1'b1, 2'd0, 16'd0, 1'b1, 3'd0, 16'h5000, 1'b0, 4'd0, "R8 old code segment");
        acc(2'd0, 16'd0, "R8 new code segment");
        wr(3'd3, 16'hFFFE);
        cyc(1'b1, 2'd0, 16'd0, 1'b0, 3'd0, 16'd0, 1'b1, 4'd3, "R3 fetch before advance");
        acc(2'd0, 16'd0, "R4 ip wrapped, cs kept");
        cyc(1'b0, 2'd0, 16'd0, 1'b1, 3'd3, 16'h0100, 1'b1, 4'd7, "R9");
        acc(2'd0, 16'd0, "R9 ip write beats advance");
        wr(3'd1, 16'h3000);
        wr(3'd4, 16'h0100);
        acc(2'd1, 16'd0, "R5 push one");
        acc(2'd1, 16'd0, "R5 push two");
        acc(2'd2, 16'd0, "R6 pop one");
        acc(2'd2, 16'd0, "R6 pop two");
        cyc(1'b1, 2'd1, 16'd0, 1'b1, 3'd4, 16'h0200, 1'b0, 4'd0, "R9 push with sp write");
        acc(2'd2, 16'd0, "R9 sp write beats push");
        wr(3'd6, 16'hABCD);
        acc(2'd0, 16'd0, "R9 unused select no effect");
        acc(2'd1, 16'd0, "R9 unused select sp");
        acc(2'd3, 16'h0000, "R9 unused select ds");
        for (int i = 0; i < 400; i++) begin
            cyc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 16'($urandom),
                ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 4)), 16'($urandom),
                1'($urandom_range(0, 1)), 4'($urandom), "R3 R4 R5 R6 R8 random mix");
        end
        idle();
        idle();
        @(posedge clk);
        #6;
        finish_run();
    end
endmodule